// File: doc/BRIEF.md
# Loopback and Line Output Controller

This block controls the output side of a serial modem that carries one main data channel and three slow side channels. The side channels pair up as request-to-send to clear-to-send, terminal-ready to set-ready, and ring-in to ring-out. A 3-bit diagnostic mode code chooses one of three modes: normal full duplex, local loopback or remote loopback. From that mode, the block decides what appears on the main received-data output and the three side outputs. It also decides what is handed to the line transmitter, and whether a loopback request flag goes to the far end.

The link framer and the lock logic sit outside this block. They supply the lock status, the far end's request flag and the received channel values. Whenever the link is out of lock, the block holds its outputs at fixed safe levels. The only exception is local loopback, which keeps working without lock. It also drives an active-low carrier-detect output. The mode code passes through a two-stage synchroniser and then a stability filter before it takes effect.

Top module: `lbc_top`

## Requirements
- R1: The mode code decodes as follows: 3'b101 selects local loopback, 3'b110 selects remote loopback, and every other code (000, 001, 010, 011, 100, 111) selects normal full duplex.
- R2: A mode code passes two synchroniser flops and must then stay unchanged for STABLE_CYCLES clocks before it takes effect. With the defaults, a code applied before clock edge k is in effect after edge k+6 and not before. A code held for only 3 clocks has no effect.
- R3: In normal mode with lock, the outputs follow the far end's values: rxd = far_main, cts = far_side[0], dsr = far_side[1], rio = far_side[2].
- R4: In local loopback, rxd = txd, cts = rts, dsr = dtr and rio = rii, and the far-end inputs have no effect on these outputs. The line transmitter still carries the local values: line_main = txd and line_side = {rii, dtr, rts}.
- R5: Local loopback behaves as in R4 whether or not the link is locked.
- R6: In remote loopback mode, when not serving a far-end request, loop_req_out is 1 and the outputs show the far end's values, mapped as in R3. In all other modes, loop_req_out is 0.
- R7: While serving, the line transmitter returns the far end's values: line_main = far_main and line_side = far_side. The same values also appear on the local outputs. Serving means far_loop_req = 1, link locked, and the mode is not local loopback.
- R8: While serving a far-end request, the node's own remote loopback request is ignored, so loop_req_out = 0.
- R9: Local loopback takes priority over a far-end request. With far_loop_req = 1, lock, and local loopback selected, the outputs and the line transmitter behave as in R4.
- R10: With no lock and no local loopback, the outputs are forced to rxd = 0, cts = 1, dsr = 1 and rio = 0.
- R11: carrier_n is 0 exactly when link_locked is 1.
- R12: After reset, the active mode is normal full duplex and the line transmitter carries the local inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_raw | input | 3 | Asynchronous diagnostic mode code |
| link_locked | input | 1 | Link lock status from the framer |
| far_loop_req | input | 1 | Remote loopback request received from the far end |
| txd | input | 1 | Local main transmit data |
| rts | input | 1 | Local request-to-send |
| dtr | input | 1 | Local terminal-ready |
| rii | input | 1 | Local ring-indicator input |
| far_main | input | 1 | Received main data from the far end |
| far_side | input | 3 | Received side channels: bit0 to CTS, bit1 to DSR, bit2 to RIO |
| rxd | output | 1 | Main received-data output |
| cts | output | 1 | Clear-to-send output |
| dsr | output | 1 | Set-ready output |
| rio | output | 1 | Ring-indicator output |
| carrier_n | output | 1 | Active-low carrier detect |
| loop_req_out | output | 1 | Remote loopback request flag to the far end |
| line_main | output | 1 | Main bit handed to the line transmitter |
| line_side | output | 3 | Side bits handed to the line transmitter, same bit positions as far_side |

## Verification
The bench builds the block with its defaults: two synchroniser stages, a stability window of four clocks and three side channels. With these values, the exact activation edge (k+6) and a rejected three-clock glitch are both short enough to test directly. Random rounds pick any of the eight mode codes and then mix lock, far request and channel values freely. This covers priority collisions such as local loopback against a far request, and remote loopback while serving.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [1:0] {
        OP_NORMAL = 2'd0,
        OP_LOCAL  = 2'd1,
        OP_REMOTE = 2'd2
    } op_t;

    localparam int MODE_W    = 3;
    localparam int SIDE_N    = 3;
    localparam logic [MODE_W-1:0] CODE_LOCAL  = 3'b101;
    localparam logic [MODE_W-1:0] CODE_REMOTE = 3'b110;
    localparam logic [MODE_W-1:0] CODE_RESET  = 3'b000;

    // Safe side-output levels while unlocked: bit0 CTS=1, bit1 DSR=1, bit2 RIO=0
    localparam logic [SIDE_N-1:0] SIDE_IDLE = 3'b011;
    localparam logic              MAIN_IDLE = 1'b0;

    typedef struct packed {
        logic main;
        logic [SIDE_N-1:0] side;
    } chan_t;

    typedef struct packed {
        logic route_local;
        logic serving;
        logic req_out;
    } ctl_t;

    function automatic op_t decode_mode(input logic [MODE_W-1:0] code);
        if (code == CODE_LOCAL)       return OP_LOCAL;
        else if (code == CODE_REMOTE) return OP_REMOTE;
        else                          return OP_NORMAL;
    endfunction

endpackage

// File: rtl/lbc_mode_filter.sv
module lbc_mode_filter
    import lbc_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [MODE_W-1:0] mode_raw,
    output op_t               op
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [SYNC_STAGES-1:0][MODE_W-1:0] sync_q;
    logic [MODE_W-1:0] cand_q;
    logic [MODE_W-1:0] active_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [MODE_W-1:0] sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= mode_raw;
            for (int i = 1; i < SYNC_STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cand_q   <= CODE_RESET;
            active_q <= CODE_RESET;
            cnt_q    <= '0;
        end else if (sync_out != cand_q) begin
            cand_q <= sync_out;
            cnt_q  <= '0;
        end else if (cnt_q != CNT_LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end else begin
            active_q <= cand_q;
        end
    end

    assign op = decode_mode(active_q);

    // R2: a newly active code is the one the synchroniser has been delivering
    a_r2_active_from_sync: assert property (@(posedge clk) disable iff (rst)
        !$stable(active_q) |-> (active_q == $past(sync_out)));

    // R12: reset returns to normal mode
    a_r12_reset_normal: assert property (@(posedge clk)
        $past(rst) |-> (op == OP_NORMAL));

endmodule

// File: rtl/lbc_arbiter.sv
module lbc_arbiter
    import lbc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_t  op,
    input  logic link_locked,
    input  logic far_loop_req,
    output ctl_t ctl
);
    logic local_on;
    logic serve_on;

    assign local_on = (op == OP_LOCAL);
    assign serve_on = far_loop_req && link_locked && !local_on;

    always_comb begin
        ctl.route_local = local_on;
        ctl.serving     = serve_on;
        ctl.req_out     = (op == OP_REMOTE) && !serve_on;
    end

    // R8: no own request while answering a far-end request
    a_r8_no_req_when_serving: assert property (@(posedge clk) disable iff (rst)
        ctl.serving |-> !ctl.req_out);

    // R9: local loopback excludes serving
    a_r9_local_beats_far: assert property (@(posedge clk) disable iff (rst)
        ctl.route_local |-> !ctl.serving);

endmodule

// File: rtl/lbc_router.sv
module lbc_router
    import lbc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctl_t  ctl,
    input  logic  link_locked,
    input  chan_t local_in,
    input  chan_t far_in,
    output chan_t user_out,
    output chan_t line_out
);
    always_comb begin
        if (ctl.route_local) begin
            user_out = local_in;
        end else if (!link_locked) begin
            user_out.main = MAIN_IDLE;
            user_out.side = SIDE_IDLE;
        end else begin
            user_out = far_in;
        end
    end

    always_comb begin
        line_out = ctl.serving ? far_in : local_in;
    end

    // R10: safe levels while unlocked outside local loopback
    a_r10_forced_unlocked: assert property (@(posedge clk) disable iff (rst)
        (!link_locked && !ctl.route_local) |-> (user_out.main == MAIN_IDLE && user_out.side == SIDE_IDLE));

    // R5: local loopback regardless of lock
    a_r5_local_any_lock: assert property (@(posedge clk) disable iff (rst)
        ctl.route_local |-> (user_out == local_in && line_out == local_in));

    // R7: serving returns received data to the line
    a_r7_serve_returns: assert property (@(posedge clk) disable iff (rst)
        ctl.serving |-> (line_out == far_in && user_out == far_in));

endmodule

// File: rtl/lbc_top.sv
module lbc_top
    import lbc_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int STABLE_CYCLES = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [2:0]  mode_raw,
    input  logic        link_locked,
    input  logic        far_loop_req,
    input  logic        txd,
    input  logic        rts,
    input  logic        dtr,
    input  logic        rii,
    input  logic        far_main,
    input  logic [2:0]  far_side,
    output logic        rxd,
    output logic        cts,
    output logic        dsr,
    output logic        rio,
    output logic        carrier_n,
    output logic        loop_req_out,
    output logic        line_main,
    output logic [2:0]  line_side
);
    op_t   op;
    ctl_t  ctl;
    chan_t local_in, far_in, user_out, line_out;

    assign local_in.main = txd;
    assign local_in.side = {rii, dtr, rts};
    assign far_in.main   = far_main;
    assign far_in.side   = far_side;

    lbc_mode_filter #(
        .SYNC_STAGES  (SYNC_STAGES),
        .STABLE_CYCLES(STABLE_CYCLES)
    ) u_filter (
        .clk     (clk),
        .rst     (rst),
        .mode_raw(mode_raw),
        .op      (op)
    );

    lbc_arbiter u_arb (
        .clk         (clk),
        .rst         (rst),
        .op          (op),
        .link_locked (link_locked),
        .far_loop_req(far_loop_req),
        .ctl         (ctl)
    );

    lbc_router u_route (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .link_locked(link_locked),
        .local_in   (local_in),
        .far_in     (far_in),
        .user_out   (user_out),
        .line_out   (line_out)
    );

    assign rxd          = user_out.main;
    assign cts          = user_out.side[0];
    assign dsr          = user_out.side[1];
    assign rio          = user_out.side[2];
    assign line_main    = line_out.main;
    assign line_side    = line_out.side;
    assign loop_req_out = ctl.req_out;
    assign carrier_n    = !link_locked;

    // R11: carrier detect tracks lock
    a_r11_carrier: assert property (@(posedge clk) disable iff (rst)
        carrier_n != link_locked);

endmodule

// File: tb/tb_lbc_top.sv
module tb_lbc_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [2:0] mode_raw = 3'b000;
    logic link_locked = 1'b0, far_loop_req = 1'b0;
    logic txd = 1'b0, rts = 1'b0, dtr = 1'b0, rii = 1'b0;
    logic far_main = 1'b0;
    logic [2:0] far_side = 3'b000;
    logic rxd, cts, dsr, rio, carrier_n, loop_req_out, line_main;
    logic [2:0] line_side;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lbc_top dut (
        .clk(clk), .rst(rst), .mode_raw(mode_raw), .link_locked(link_locked),
        .far_loop_req(far_loop_req), .txd(txd), .rts(rts), .dtr(dtr), .rii(rii),
        .far_main(far_main), .far_side(far_side), .rxd(rxd), .cts(cts), .dsr(dsr),
        .rio(rio), .carrier_n(carrier_n), .loop_req_out(loop_req_out),
        .line_main(line_main), .line_side(line_side)
    );

    // 0 normal, 1 local, 2 remote (R1)
    function automatic int exp_op(input logic [2:0] c);
        if (c == 3'b101) return 1;
        if (c == 3'b110) return 2;
        return 0;
    endfunction

    // packed {rio,dsr,cts,rxd}
    function automatic logic [3:0] exp_user(input int op, input logic lk);
        if (op == 1) return {rii, dtr, rts, txd};
        if (!lk) return 4'b0110;
        return {far_side, far_main};
    endfunction

    function automatic logic [3:0] exp_line(input int op, input logic lk, input logic fr);
        if (fr && lk && op != 1) return {far_side, far_main};
        return {rii, dtr, rts, txd};
    endfunction

    function automatic logic exp_req(input int op, input logic lk, input logic fr);
        return (op == 2) && !(fr && lk);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input int op);
        chk({tag, " user"}, {4'b0, rio, dsr, cts, rxd}, {4'b0, exp_user(op, link_locked)});
        chk({tag, " line"}, {4'b0, line_side, line_main}, {4'b0, exp_line(op, link_locked, far_loop_req)});
        chk({tag, " req"}, {7'b0, loop_req_out}, {7'b0, exp_req(op, link_locked, far_loop_req)});
        chk({tag, " R11 carrier"}, {7'b0, carrier_n}, {7'b0, !link_locked});
    endtask

    task automatic rand_data();
        {txd, rts, dtr, rii, far_main} = 5'($urandom);
        far_side = 3'($urandom);
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        wait_edges(3);
        rst = 1'b0;
        // R12: reset state, normal mode, unlocked forced levels
        txd = 1'b1; rts = 1'b1; far_main = 1'b1; far_side = 3'b101;
        #1 check_all("R12 reset R10", 0);

        // R2 exact activation edge: local loopback unlocked makes rxd follow txd
        @(negedge clk);
        mode_raw = 3'b101; txd = 1'b1;
        repeat (6) @(posedge clk);
        #1 chk("R2 not yet active", {7'b0, rxd}, 8'd0);
        @(posedge clk);
        #1 chk("R2 active at k+6 R5", {7'b0, rxd}, 8'd1);

        // R2 glitch of 3 clocks: back to normal first
        @(negedge clk);
        mode_raw = 3'b000; wait_edges(10);
        mode_raw = 3'b101; wait_edges(3);
        mode_raw = 3'b000; wait_edges(12);
        txd = 1'b1; link_locked = 1'b0;
        #1 chk("R2 glitch ignored", {7'b0, rxd}, 8'd0);

        // R8 directed: remote mode while serving
        mode_raw = 3'b110; wait_edges(10);
        link_locked = 1'b1; far_loop_req = 1'b1; rand_data();
        #1 check_all("R8 R7 serving", 2);
        far_loop_req = 1'b0;
        #1 check_all("R6 remote request", 2);

        // R9 directed: local beats far request
        @(negedge clk);
        mode_raw = 3'b101; wait_edges(10);
        link_locked = 1'b1; far_loop_req = 1'b1; rand_data();
        #1 check_all("R9 R4 local priority", 1);

        // Random rounds over all codes: R1 R3 R4 R5 R6 R7 R10
        for (int r = 0; r < 120; r++) begin
            logic [2:0] code;
            code = 3'($urandom);
            @(negedge clk);
            mode_raw = code; wait_edges(10);
            for (int s = 0; s < 6; s++) begin
                link_locked = 1'($urandom);
                far_loop_req = 1'($urandom);
                rand_data();
                #1 check_all("R1 R3 R4 R6 R7 R10 random", exp_op(code));
                @(negedge clk);
            end
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule